// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a single-clock synchronous memory whose shared data bus never idles between a read and a write. Every control input is captured on the rising clock edge. A read returns its data in the same cycle that follows the edge which captured its address. A write captures its address and byte-lane mask on one edge and takes its data on the following enabled edge. The write data phase therefore lines up with the slot that a read would use for its output, so back-to-back reads and writes use every bus cycle.

A cycle type is fixed only when the load/advance input is low. When that input is high, the previous read or write carries on at the next address of a four-word burst. The burst follows either a wrapping count or an XOR sequence. Three chip selects pick the device. A clock-enable input can freeze the whole block for any number of edges. The array is a parameterised register array, and the output has a separate data-out bus and a drive/valid flag that is gated by an asynchronous output enable.

Top module: `lw_sram`

## Requirements
- R1: After reset, `drive` is low and `dout` is zero, and the block is in the deselected state.
- R2: An enabled edge with `ld_n`=0, the device selected and `wr_n`=1 starts a read of `addr`. In the cycle after that edge, with `oe_n`=0, `drive` is high and `dout` shows the stored word at `addr`.
- R3: The device is selected only when `cs_n`=0, `cs_hi`=1 and `cs2_n`=0. Any other combination loaded with `ld_n`=0 starts a deselect cycle, and `drive` stays low through it.
- R4: A write loaded with `wr_n`=0 on an enabled edge takes its data from `din` on the next enabled edge and stores it at that write's address.
- R5: Lane i covers `din` bits [8i+7:8i]. It is written only when `be_n[i]`=0 on the address edge of the write. Lanes with `be_n[i]`=1 keep their old contents.
- R6: An edge with `cke_n`=1 is ignored. Nothing is captured, the output state is held, and a pending write waits for the next enabled edge to take its data.
- R7: With `ld_n`=1, the previous read or write goes on at the next burst address. When `lin_burst`=1, the two low address bits are (base + k) mod 4 on the k-th access, and the upper bits do not change.
- R8: When `lin_burst`=0, the two low address bits of the k-th burst access are base XOR k.
- R9: A read of an address on the edge right after a write to that address returns the newly written bytes merged with the unwritten bytes from the array, with no idle cycle in between.
- R10: `drive` is low during the data cycle of a write and during deselect cycles. A deselect cycle continued with `ld_n`=1 remains a deselect cycle.
- R11: When `oe_n`=1, `drive` is low and `dout` is zero, at once and without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; when high the edge is ignored |
| cs_n | input | 1 | Active-low chip select |
| cs_hi | input | 1 | Active-high chip select |
| cs2_n | input | 1 | Second active-low chip select |
| ld_n | input | 1 | Low: load a new cycle; high: advance the burst |
| wr_n | input | 1 | Low: write, high: read (sampled when loading) |
| lin_burst | input | 1 | 1: wrapping-add burst order, 0: XOR burst order |
| addr | input | AW | Word address |
| be_n | input | LANES | Active-low byte-lane write enables |
| din | input | DW | Write data, one enabled edge after the address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dout | output | DW | Flow-through read data, zero when not driving |
| drive | output | 1 | High while `dout` carries valid read data |

## Verification
Several rules are checked by assertions on every cycle: frozen state across suspended edges, a dark output after a loaded deselect or write, the upper address bits held while a burst advances, and a freshly loaded address appearing as the current one. Data content can only be shown by the bench's scenarios. That covers lane-masked merges, write data taken after a suspended edge, read-after-write coherency, the two burst orders walking a prefilled block, and the immediate effect of the output enable.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int WORDS  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cke_n,
  input  logic                           cs_n,
  input  logic                           cs_hi,
  input  logic                           cs2_n,
  input  logic                           ld_n,
  input  logic                           wr_n,
  input  logic                           lin_burst,
  input  logic [$clog2(WORDS)-1:0]       addr,
  input  logic [LANES-1:0]               be_n,
  input  logic [LANES*LANE_W-1:0]        din,
  input  logic                           oe_n,
  output logic [LANES*LANE_W-1:0]        dout,
  output logic                           drive
);
  localparam int AW = $clog2(WORDS);
  localparam int DW = LANES * LANE_W;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_t;

  op_t             op_q;
  logic [AW-1:0]   base_q;
  logic [1:0]      cnt_q;
  logic [LANES-1:0] be_q;
  logic [DW-1:0]   mem [WORDS];

  logic            sel_ok;
  logic [1:0]      low_bits;
  logic [AW-1:0]   cur_addr;

  assign sel_ok   = !cs_n && cs_hi && !cs2_n;
  assign low_bits = lin_burst ? base_q[1:0] + cnt_q : base_q[1:0] ^ cnt_q;
  assign cur_addr = {base_q[AW-1:2], low_bits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      be_q   <= '1;
    end else if (!cke_n) begin
      if (!ld_n) begin
        op_q   <= !sel_ok ? OP_IDLE : (wr_n ? OP_RD : OP_WR);
        base_q <= addr;
        cnt_q  <= '0;
      end else if (op_q != OP_IDLE) begin
        cnt_q  <= cnt_q + 2'd1;
      end
      be_q <= be_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cke_n && op_q == OP_WR) begin
      for (int i = 0; i < LANES; i++) begin
        if (!be_q[i]) mem[cur_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
      end
    end
  end

  assign drive = (op_q == OP_RD) && !oe_n;
  assign dout  = drive ? mem[cur_addr] : '0;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(cke_n) |-> $stable(cur_addr) && $stable(op_q)); // R6
  AST_DESEL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!cke_n && !ld_n && !sel_ok) |-> !drive); // R3
  AST_WDATA_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!cke_n && !ld_n && sel_ok && !wr_n) |-> !drive); // R10
  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!cke_n && ld_n) |-> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R7
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!cke_n && !ld_n) |-> cur_addr == $past(addr)); // R2
endmodule

// File: tb/lw_sram_test.sv
module lw_sram_test;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_n = 1'b0, cs_n = 1'b1, cs_hi = 1'b0, cs2_n = 1'b1;
  logic ld_n = 1'b0, wr_n = 1'b1, lin_burst = 1'b1, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] be_n = 4'hF;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic drive;

  int checks = 0;
  int errors = 0;

  lw_sram uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs_n(cs_n), .cs_hi(cs_hi),
    .cs2_n(cs2_n), .ld_n(ld_n), .wr_n(wr_n), .lin_burst(lin_burst),
    .addr(addr), .be_n(be_n), .din(din), .oe_n(oe_n), .dout(dout), .drive(drive)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic dv, input logic [DW-1:0] dd,
                     input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (dv !== ev || dd !== ed) begin
      errors++;
      $display("FAIL %s: drive=%0b dout=%h expected drive=%0b dout=%h", req, dv, dd, ev, ed);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(input logic l, input logic w, input logic [AW-1:0] a,
                     input logic [3:0] b, input logic [DW-1:0] d);
    cs_n = 1'b0; cs_hi = 1'b1; cs2_n = 1'b0;
    ld_n = l; wr_n = w; addr = a; be_n = b; din = d;
    tick();
  endtask

  task automatic t_reset;
    chk("R1", drive, dout, 1'b0, '0);
  endtask

  task automatic t_write_read;
    cmd(1'b0, 1'b0, 6'd5, 4'h0, '0);
    chk("R10", drive, dout, 1'b0, '0);
    cmd(1'b0, 1'b1, 6'd5, 4'hF, 32'hC0DE_0005);
    chk("R9", drive, dout, 1'b1, 32'hC0DE_0005);
    cmd(1'b0, 1'b0, 6'd6, 4'h0, 32'hDEAD_BEEF);
    chk("R4", drive, dout, 1'b0, '0);
    cmd(1'b0, 1'b1, 6'd6, 4'hF, 32'h0606_0606);
    chk("R4", drive, dout, 1'b1, 32'h0606_0606);
  endtask

  task automatic t_bytes;
    cmd(1'b0, 1'b0, 6'd7, 4'h0, '0);
    cmd(1'b0, 1'b0, 6'd7, 4'b1010, 32'h1122_3344);
    cmd(1'b0, 1'b1, 6'd7, 4'hF, 32'hAABB_CCDD);
    chk("R5", drive, dout, 1'b1, 32'h11BB_33DD);
  endtask

  task automatic t_select;
    for (int c = 0; c < 7; c++) begin
      ld_n = 1'b0; wr_n = 1'b1; addr = 6'd5; be_n = 4'hF;
      cs_n = c[0]; cs_hi = ~c[1]; cs2_n = c[2];
      if (c == 0) cs_n = 1'b1;
      tick();
      chk("R3", drive, dout, 1'b0, '0);
    end
    cmd(1'b1, 1'b1, 6'd0, 4'hF, '0);
    chk("R10", drive, dout, 1'b0, '0);
    cmd(1'b0, 1'b1, 6'd5, 4'hF, '0);
    chk("R2", drive, dout, 1'b1, 32'hC0DE_0005);
  endtask

  task automatic t_oe;
    oe_n = 1'b1;
    #1;
    chk("R11", drive, dout, 1'b0, '0);
    oe_n = 1'b0;
    #1;
    chk("R11", drive, dout, 1'b1, 32'hC0DE_0005);
  endtask

  task automatic t_suspend;
    cke_n = 1'b1;
    cmd(1'b0, 1'b1, 6'd6, 4'hF, '0);
    chk("R6", drive, dout, 1'b1, 32'hC0DE_0005);
    cke_n = 1'b0;
    cmd(1'b0, 1'b0, 6'd10, 4'h0, '0);
    cke_n = 1'b1;
    cmd(1'b0, 1'b1, 6'd11, 4'hF, 32'hBAD0_BAD0);
    cke_n = 1'b0;
    cmd(1'b0, 1'b1, 6'd10, 4'hF, 32'h1010_1010);
    chk("R6", drive, dout, 1'b1, 32'h1010_1010);
  endtask

  task automatic t_bursts;
    lin_burst = 1'b1;
    cmd(1'b0, 1'b0, 6'd8, 4'h0, '0);
    cmd(1'b1, 1'b1, 6'd0, 4'h0, 32'hA000_0008);
    cmd(1'b1, 1'b1, 6'd0, 4'h0, 32'hA000_0009);
    cmd(1'b1, 1'b1, 6'd0, 4'h0, 32'hA000_000A);
    cmd(1'b0, 1'b1, 6'd10, 4'hF, 32'hA000_000B);
    chk("R7", drive, dout, 1'b1, 32'hA000_000A);
    cmd(1'b1, 1'b0, 6'd0, 4'hF, '0);
    chk("R7", drive, dout, 1'b1, 32'hA000_000B);
    cmd(1'b1, 1'b0, 6'd0, 4'hF, '0);
    chk("R7", drive, dout, 1'b1, 32'hA000_0008);
    cmd(1'b1, 1'b0, 6'd0, 4'hF, '0);
    chk("R7", drive, dout, 1'b1, 32'hA000_0009);
    lin_burst = 1'b0;
    cmd(1'b0, 1'b1, 6'd9, 4'hF, '0);
    chk("R8", drive, dout, 1'b1, 32'hA000_0009);
    cmd(1'b1, 1'b1, 6'd0, 4'hF, '0);
    chk("R8", drive, dout, 1'b1, 32'hA000_0008);
    cmd(1'b1, 1'b1, 6'd0, 4'hF, '0);
    chk("R8", drive, dout, 1'b1, 32'hA000_000B);
    cmd(1'b1, 1'b1, 6'd0, 4'hF, '0);
    chk("R8", drive, dout, 1'b1, 32'hA000_000A);
    lin_burst = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: drive=%0b dout=%h expected run to end", drive, dout);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_write_read();
    t_bytes();
    t_select();
    t_oe();
    t_suspend();
    t_bursts();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule